// File: doc/BRIEF.md
# Device Signature Identification Sequencer

This block performs the identification step that a device programmer runs before it selects a programming algorithm. After a start pulse, it raises a flag that asks an external driver to place the high identification voltage on one address pin. It holds every address line low and waits for the voltage to settle. It then reads two bytes through the normal chip-enable and output-enable controls. Address bit 0 selects the byte: low for the manufacturer byte, high for the device byte.

Each read waits the same access time as an ordinary array read. The two captured bytes are compared with expected manufacturer and device codes, which are parameters. The block then removes the flag and returns the bus to idle. Only after that does it issue a one-cycle done pulse. The done pulse comes whether or not the codes matched. The captured bytes and the match flag stay on the outputs until the next start.

The settle wait is given in microseconds and converted to clock cycles from the clock frequency parameter. The circuit that generates the high voltage is outside this block.

Top module: `sig_id_seq`

## Requirements
- R1: After reset, hv_req is 0, ce_n and oe_n are 1, mem_addr is 0, id_lo, id_hi and match are 0, and done is 0.
- R2: A start pulse sampled while idle raises hv_req on the next cycle. hv_req then stays high with ce_n and oe_n high for exactly CLK_MHZ*SETTLE_US cycles before the first read.
- R3: While hv_req is high, every bit of mem_addr above bit 0 is 0.
- R4: The first read drives mem_addr[0]=0 with ce_n=0 and oe_n=0 for exactly ACC_CYC cycles. mem_data is captured into id_lo at the end of this read.
- R5: The second read follows at once. It drives mem_addr[0]=1 with ce_n=0 and oe_n=0 for exactly ACC_CYC cycles, and mem_data is captured into id_hi at its end.
- R6: At done, match is 1 exactly when id_lo equals MFR_CODE (default 8'h20) and id_hi equals DEV_CODE (default 8'h61). match is cleared by the next accepted start.
- R7: Before done, hv_req falls and ce_n and oe_n are high for at least one cycle. done is a single-cycle pulse and is issued whether or not the codes match.
- R8: A start pulse received while a sequence is running is ignored. Exactly one done pulse results.
- R9: ce_n and oe_n are low only while hv_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an identification sequence when idle |
| mem_data | input | 8 | Data lines from the memory device |
| hv_req | output | 1 | Requests the high identification voltage on the address pin |
| mem_addr | output | ADDR_W | Address lines to the device; only bit 0 is ever driven high |
| ce_n | output | 1 | Active-low chip enable |
| oe_n | output | 1 | Active-low output enable |
| id_lo | output | 8 | Captured manufacturer byte |
| id_hi | output | 8 | Captured device byte |
| match | output | 1 | Both bytes equal their expected codes |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The sequence is run against a device model that returns its two code bytes only while hv_req is high and the read has been held for the access time. Four code pairs are used:
- The correct pair must set match.
- A pair with a wrong manufacturer byte must clear match.
- A pair with a wrong device byte must clear match.
- The swapped pair must also clear match, which shows that the byte selected by address bit 0 lands in the right register.

The model returns a poison value when a read is too short, so a shortened access wait shows up as wrong captured bytes. The bench also measures the settle, read and release windows, and it issues a second start during a running sequence to show that only one done results.

// File: rtl/sig_pkg.sv
package sig_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETTLE  = 3'd1,
    ST_RD_LO   = 3'd2,
    ST_RD_HI   = 3'd3,
    ST_RELEASE = 3'd4,
    ST_DONE    = 3'd5
  } seq_state_t;

  // Settle wait in clock cycles from clock MHz and microseconds.
  function automatic int settle_cycles(input int clk_mhz, input int wait_us);
    return clk_mhz * wait_us;
  endfunction

  // Identification passes only when both bytes equal their expected codes.
  function automatic logic codes_match(input logic [7:0] lo, input logic [7:0] hi,
                                       input logic [7:0] exp_lo, input logic [7:0] exp_hi);
    return (lo == exp_lo) && (hi == exp_hi);
  endfunction

endpackage

// File: rtl/sig_wait_timer.sv
module sig_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sig_code_match.sv
module sig_code_match #(
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'h61
) (
  input  logic [7:0] byte_lo,
  input  logic [7:0] byte_hi,
  output logic       codes_ok
);
  assign codes_ok = sig_pkg::codes_match(byte_lo, byte_hi, MFR_CODE, DEV_CODE);
endmodule

// File: rtl/sig_id_seq.sv
module sig_id_seq #(
  parameter int         ADDR_W    = 18,
  parameter int         CLK_MHZ   = 50,
  parameter int         SETTLE_US = 2,
  parameter int         ACC_CYC   = 4,
  parameter logic [7:0] MFR_CODE  = 8'h20,
  parameter logic [7:0] DEV_CODE  = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        mem_data,
  output logic              hv_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ce_n,
  output logic              oe_n,
  output logic [7:0]        id_lo,
  output logic [7:0]        id_hi,
  output logic              match,
  output logic              done
);
  import sig_pkg::*;

  localparam int SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_US);
  localparam int MAX_WAIT   = (SETTLE_CYC > ACC_CYC) ? SETTLE_CYC : ACC_CYC;
  localparam int CNT_W      = $clog2(MAX_WAIT + 1);

  seq_state_t state_q, state_d;
  logic             timer_load, timer_expired;
  logic [CNT_W-1:0] timer_val;
  logic             codes_ok;

  // Named internal events, brought out for the checker.
  logic capture_lo, capture_hi, seq_busy, in_read;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start)         state_d = ST_SETTLE;
      ST_SETTLE:  if (timer_expired) state_d = ST_RD_LO;
      ST_RD_LO:   if (timer_expired) state_d = ST_RD_HI;
      ST_RD_HI:   if (timer_expired) state_d = ST_RELEASE;
      ST_RELEASE:                    state_d = ST_DONE;
      ST_DONE:                       state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign timer_load = (state_d != state_q);
  assign timer_val  = (state_d == ST_SETTLE) ? CNT_W'(SETTLE_CYC - 1) : CNT_W'(ACC_CYC - 1);

  sig_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .load_val(timer_val),
    .expired (timer_expired)
  );

  assign capture_lo = (state_q == ST_RD_LO) && timer_expired;
  assign capture_hi = (state_q == ST_RD_HI) && timer_expired;
  assign seq_busy   = (state_q != ST_IDLE);
  assign in_read    = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);

  sig_code_match #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_cmp (
    .byte_lo (id_lo),
    .byte_hi (id_hi),
    .codes_ok(codes_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_lo <= '0;
      id_hi <= '0;
      match <= 1'b0;
    end else begin
      if (state_q == ST_IDLE && start) match <= 1'b0;
      if (capture_lo)                  id_lo <= mem_data;
      if (capture_hi)                  id_hi <= mem_data;
      if (state_q == ST_RELEASE)       match <= codes_ok;
    end
  end

  assign hv_req   = (state_q == ST_SETTLE) || in_read;
  assign ce_n     = !in_read;
  assign oe_n     = !in_read;
  assign mem_addr = {{(ADDR_W-1){1'b0}}, (state_q == ST_RD_HI)};
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/sig_id_seq_chk.sv
module sig_id_seq_chk #(
  parameter int         ADDR_W   = 18,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'h61
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hv_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic [7:0]        id_lo,
  input logic [7:0]        id_hi,
  input logic              match,
  input logic              done,
  input logic              capture_lo,
  input logic              capture_hi
);
  // R2
  hv_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_req) |-> (ce_n && oe_n));

  // R3
  addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hv_req |-> (mem_addr[ADDR_W-1:1] == '0));

  // R4
  lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_lo |-> (!ce_n && !oe_n && !mem_addr[0]));

  // R5
  hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_hi |-> (!ce_n && !oe_n && mem_addr[0]));

  // R6
  match_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (match == ((id_lo == MFR_CODE) && (id_hi == DEV_CODE))));

  // R7
  release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!hv_req && ce_n && oe_n && !$past(hv_req)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  enable_in_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n || !oe_n) |-> hv_req);
endmodule

bind sig_id_seq sig_id_seq_chk #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hv_req    (hv_req),
  .mem_addr  (mem_addr),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .id_lo     (id_lo),
  .id_hi     (id_hi),
  .match     (match),
  .done      (done),
  .capture_lo(capture_lo),
  .capture_hi(capture_hi)
);

// File: tb/test_sig_id_seq.sv
module test_sig_id_seq;
  localparam int ADDR_W = 18;
  localparam int SETTLE_EXP = 50 * 2;
  localparam int ACC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] mem_data;
  logic hv_req, ce_n, oe_n, match, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] id_lo, id_hi;

  always #10 clk = ~clk;

  sig_id_seq #(.ADDR_W(ADDR_W), .CLK_MHZ(50), .SETTLE_US(2), .ACC_CYC(ACC)) i_sig_id_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_data(mem_data),
    .hv_req(hv_req), .mem_addr(mem_addr), .ce_n(ce_n), .oe_n(oe_n),
    .id_lo(id_lo), .id_hi(id_hi), .match(match), .done(done)
  );

  // Device model: codes only in identification mode after the access time.
  logic [7:0] dev_mfr = 8'h20;
  logic [7:0] dev_dev = 8'h61;
  logic [ADDR_W+2:0] key, key_prev;
  int rd_cnt, hv_cnt;
  assign key = {hv_req, ce_n, oe_n, mem_addr};
  always @(posedge clk) begin
    rd_cnt   <= (key == key_prev) ? rd_cnt + 1 : 0;
    key_prev <= key;
    hv_cnt   <= hv_req ? hv_cnt + 1 : 0;
  end
  always_comb begin
    if (hv_req && !ce_n && !oe_n && mem_addr[ADDR_W-1:1] == '0 &&
        key == key_prev && rd_cnt >= ACC - 2 && hv_cnt >= SETTLE_EXP)
      mem_data = mem_addr[0] ? dev_dev : dev_mfr;
    else
      mem_data = 8'hEE;
  end

  int n_chk = 0, n_bad = 0;
  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed { logic [7:0] lo; logic [7:0] hi; logic m; } exp_t;
  exp_t exp_q[$];
  int done_cnt = 0;

  // Monitor: window measurement and scoreboard compare at each done.
  int settle_len = 0, lo_len = 0, hi_len = 0, rel_len = 0;
  logic addr_viol = 1'b0, en_viol = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hv_req && mem_addr[ADDR_W-1:1] != '0) addr_viol = 1'b1;
      if ((!ce_n || !oe_n) && !hv_req) en_viol = 1'b1;
      if (done) begin
        exp_t e;
        done_cnt++;
        check(settle_len == SETTLE_EXP, "R2 settle length", settle_len, SETTLE_EXP);
        check(lo_len == ACC, "R4 low read length", lo_len, ACC);
        check(hi_len == ACC, "R5 high read length", hi_len, ACC);
        check(rel_len >= 1 && !hv_req && ce_n && oe_n, "R7 release before done", rel_len, 1);
        check(!addr_viol, "R3 upper address low", addr_viol, 0);
        check(!en_viol, "R9 enables only in mode", en_viol, 0);
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected done", done_cnt, 0);
        else begin
          e = exp_q.pop_front();
          check(id_lo == e.lo, "R4 id_lo", id_lo, e.lo);
          check(id_hi == e.hi, "R5 id_hi", id_hi, e.hi);
          check(match == e.m, "R6 match", match, e.m);
        end
        settle_len = 0; lo_len = 0; hi_len = 0; rel_len = 0;
      end else begin
        if (hv_req && ce_n && oe_n && lo_len == 0) settle_len++;
        if (!oe_n && !mem_addr[0]) lo_len++;
        if (!oe_n && mem_addr[0]) hi_len++;
        if (!hv_req && hi_len > 0) rel_len++;
      end
    end
  end

  // Driver: push expected result, pulse start, wait for done.
  task automatic run_seq(input logic [7:0] mfr, input logic [7:0] dv, input logic extra_start);
    exp_t e;
    dev_mfr = mfr; dev_dev = dv;
    e.lo = mfr; e.hi = dv; e.m = (mfr == 8'h20) && (dv == 8'h61);
    exp_q.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(match == 1'b0, "R6 match cleared on start", match, 0);
    check(hv_req == 1'b1, "R2 hv_req after start", hv_req, 1);
    if (extra_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!done, "R7 done single cycle", done, 0);
  endtask

  int cycles = 0;
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!hv_req && ce_n && oe_n, "R1 reset controls", {hv_req, ce_n, oe_n}, 3'b011);
    check(mem_addr == '0 && !done, "R1 reset addr/done", mem_addr, 0);
    check(id_lo == 0 && id_hi == 0 && !match, "R1 reset results", {id_lo, id_hi, match}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_seq(8'h20, 8'h61, 1'b0);   // R6 correct pair
    check(match == 1'b1, "R6 match held after done", match, 1);
    run_seq(8'h21, 8'h61, 1'b0);   // R6 wrong manufacturer
    run_seq(8'h20, 8'h60, 1'b0);   // R6 wrong device
    run_seq(8'h61, 8'h20, 1'b0);   // R5 byte order
    run_seq(8'h20, 8'h61, 1'b1);   // R8 extra start while running
    repeat (300) @(negedge clk);
    check(done_cnt == 5, "R8 one done per accepted start", done_cnt, 5);
    check(!hv_req && ce_n && oe_n, "R8 idle after ignored start", {hv_req, ce_n, oe_n}, 3'b011);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule